// File: doc/BRIEF.md
# Quarter-Operated Two-Drink Vending Controller

This block is the sequencing core of a vending machine that sells two drinks, each costing fifty cents, and takes quarters only. A coin-detect pulse, two drink buttons and a refund button come in. Four latch-control lines go out: drop drink A, drop drink B, give the coins back, and move the held coins into the cash box.

Credit is kept as zero, one or two quarters. A third quarter does not raise it above two. A drink button or a refund request moves the machine into a short action state. That state drives the matching latch lines for exactly one clock and then falls back to zero credit without needing any input. The latch lines are decoded only from the registered state. A button held for a long time therefore yields a single, clean one-cycle pulse, and a button press can never open a latch while the credit is too low.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the machine to zero credit, and all four latch outputs read 0 in the following cycle.
- R2: Each cycle with `coin_in` high raises the credit by one quarter, from zero to one and from one to two.
- R3: A coin received while holding two quarters leaves the credit at two, so a single purchase afterwards empties it completely.
- R4: While the credit is below two quarters, `sel_a` and `sel_b` cause no latch pulse and leave the credit unchanged.
- R5: With two quarters held, `sel_a` sampled at a rising edge drives `rel_a` and `take_coins` high together for exactly the next cycle, and the credit becomes zero.
- R6: With two quarters held, `sel_b` (with `sel_a` and `refund_req` low) drives `rel_b` and `take_coins` high for exactly the next cycle, and the credit becomes zero.
- R7: With one or two quarters held, `refund_req` drives `rel_refund` alone high for exactly the next cycle, and the credit becomes zero.
- R8: With zero credit, `refund_req` produces no pulse. A coin in the same cycle still counts.
- R9: With two quarters held, the priority is `refund_req` over `sel_a` over `sel_b`, and only one action is taken.
- R10: An action cycle always returns to zero credit. Inputs held or asserted during the pulse cycle, coins included, are ignored.
- R11: With one quarter held, a refund request wins over a coin arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_in | input | 1 | One-cycle pulse per quarter received |
| sel_a | input | 1 | Drink A button level |
| sel_b | input | 1 | Drink B button level |
| refund_req | input | 1 | Refund button level |
| rel_a | output | 1 | Open drink A latch for one cycle |
| rel_b | output | 1 | Open drink B latch for one cycle |
| rel_refund | output | 1 | Open coin-return latch for one cycle |
| take_coins | output | 1 | Open cash-box latch for one cycle |

## Verification
A wrong state becomes visible at the ports one cycle later, or it stays hidden until a later purchase. A wrong action state gives a wrong or missing latch pulse in the cycle right after the button is sampled. A wrong credit value shows no pulse at all. It comes out only when the number of coins needed before `sel_a` produces a vend is counted. For that reason the bench follows every stimulus with such a count. The count runs one to three cycles.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STATE_W = 3;
    localparam int LATCH_N = 4;

    // Credit states hold the quarter count; action states last one cycle.
    typedef enum logic [STATE_W-1:0] {
        ST_EMPTY  = 3'd0,
        ST_ONE    = 3'd1,
        ST_PAID   = 3'd2,
        ST_GIVE_A = 3'd3,
        ST_GIVE_B = 3'd4,
        ST_RETURN = 3'd5
    } vstate_e;

    typedef struct packed {
        logic coin;
        logic pick_a;
        logic pick_b;
        logic refund;
    } vreq_t;

    typedef struct packed {
        logic drop_a;
        logic drop_b;
        logic drop_refund;
        logic keep;
    } vlatch_t;

    typedef struct packed {
        vstate_e state;
    } vregs_t;

endpackage

// File: rtl/vend_next_state.sv
module vend_next_state
    import vend_pkg::*;
(
    input  vstate_e cur,
    input  vreq_t   req,
    output vstate_e nxt
);

    always_comb begin
        nxt = ST_EMPTY;
        case (cur)
            ST_EMPTY: begin
                // nothing to give back, so only a coin matters
                nxt = req.coin ? ST_ONE : ST_EMPTY;
            end
            ST_ONE: begin
                if (req.refund)
                    nxt = ST_RETURN;
                else if (req.coin)
                    nxt = ST_PAID;
                else
                    nxt = ST_ONE;
            end
            ST_PAID: begin
                // refund first, then A, then B; extra coins saturate
                if (req.refund)
                    nxt = ST_RETURN;
                else if (req.pick_a)
                    nxt = ST_GIVE_A;
                else if (req.pick_b)
                    nxt = ST_GIVE_B;
                else
                    nxt = ST_PAID;
            end
            ST_GIVE_A, ST_GIVE_B, ST_RETURN: begin
                nxt = ST_EMPTY;
            end
            default: begin
                nxt = ST_EMPTY;
            end
        endcase
    end

endmodule

// File: rtl/vend_latch_decode.sv
module vend_latch_decode
    import vend_pkg::*;
(
    input  vstate_e cur,
    output vlatch_t lat
);

    always_comb begin
        lat = '0;
        case (cur)
            ST_GIVE_A: begin
                lat.drop_a = 1'b1;
                lat.keep   = 1'b1;
            end
            ST_GIVE_B: begin
                lat.drop_b = 1'b1;
                lat.keep   = 1'b1;
            end
            ST_RETURN: begin
                lat.drop_refund = 1'b1;
            end
            default: begin
                lat = '0;
            end
        endcase
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_in,
    input  logic sel_a,
    input  logic sel_b,
    input  logic refund_req,
    output logic rel_a,
    output logic rel_b,
    output logic rel_refund,
    output logic take_coins
);

    vregs_t  regs_d;
    vregs_t  regs_q;
    vreq_t   req;
    vstate_e state_q;
    vstate_e state_nx;
    vlatch_t lat;

    assign req     = '{coin: coin_in, pick_a: sel_a, pick_b: sel_b, refund: refund_req};
    assign state_q = regs_q.state;

    vend_next_state u_next (
        .cur (state_q),
        .req (req),
        .nxt (state_nx)
    );

    vend_latch_decode u_dec (
        .cur (state_q),
        .lat (lat)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= '{state: ST_EMPTY};
        else
            regs_q <= regs_d;
    end

    assign rel_a      = lat.drop_a;
    assign rel_b      = lat.drop_b;
    assign rel_refund = lat.drop_refund;
    assign take_coins = lat.keep;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    coin_in,
    input logic    sel_a,
    input logic    sel_b,
    input logic    refund_req,
    input logic    rel_a,
    input logic    rel_b,
    input logic    rel_refund,
    input logic    take_coins,
    input vstate_e state_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !(rel_a || rel_b || rel_refund || take_coins));

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rel_a, rel_b, rel_refund}));

    // R5
    vend_a_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rel_a |-> take_coins && $past(sel_a) && !$past(refund_req));

    // R6
    vend_b_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rel_b |-> take_coins && $past(sel_b) && !$past(sel_a) && !$past(refund_req));

    // R7
    refund_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rel_refund |-> $past(refund_req) && !take_coins);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_a || rel_b || rel_refund) |=> !(rel_a || rel_b || rel_refund || take_coins));

    // R10
    action_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GIVE_A || state_q == ST_GIVE_B || state_q == ST_RETURN)
        |=> state_q == ST_EMPTY);

    // R3
    credit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAID && !refund_req && !sel_a && !sel_b) |=> state_q == ST_PAID);

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .coin_in    (coin_in),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .refund_req (refund_req),
    .rel_a      (rel_a),
    .rel_b      (rel_b),
    .rel_refund (rel_refund),
    .take_coins (take_coins),
    .state_q    (state_q)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_in = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic refund_req = 1'b0;
    logic rel_a, rel_b, rel_refund, take_coins;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    vend_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .coin_in    (coin_in),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .refund_req (refund_req),
        .rel_a      (rel_a),
        .rel_b      (rel_b),
        .rel_refund (rel_refund),
        .take_coins (take_coins)
    );

    function automatic logic [3:0] outs();
        return {rel_a, rel_b, rel_refund, take_coins};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // apply inputs for one clock; returns at the next falling edge
    task automatic drive(input logic c, input logic a, input logic b, input logic r);
        coin_in = c; sel_a = a; sel_b = b; refund_req = r;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(0, 0, 0, 0);
        rst = 1'b0;
    endtask

    // count coins needed before sel_a vends: credit = 2 - coins
    task automatic probe(output int cr);
        cr = -1;
        for (int n = 0; n < 3; n++) begin
            drive(0, 1, 0, 0);
            if (rel_a && take_coins) begin
                cr = 2 - n;
                drive(0, 0, 0, 0);
                break;
            end
            drive(1, 0, 0, 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int cr;
        @(negedge clk);
        drive(0, 0, 0, 0);
        check("R1 reset outputs", outs(), 0);
        rst = 1'b0;
        probe(cr);
        check("R1 reset credit", cr, 0);

        // reset mid-transaction clears two quarters
        drive(1, 0, 0, 0);
        drive(1, 0, 0, 0);
        do_reset();
        check("R1 reset outputs after credit", outs(), 0);
        probe(cr);
        check("R1 credit cleared", cr, 0);

        // full sweep: every start credit x every input combination
        for (int c = 0; c < 3; c++) begin
            for (int v = 0; v < 16; v++) begin
                logic ci, a, b, r;
                logic [3:0] exp_o;
                int exp_cr;
                string tag;
                ci = v[3]; a = v[2]; b = v[1]; r = v[0];
                exp_o = 4'b0000;
                exp_cr = c;
                tag = "R2";
                if (c == 0) begin
                    exp_cr = ci ? 1 : 0;
                    tag = r ? "R8" : ((a || b) ? "R4" : "R2");
                end else if (c == 1) begin
                    if (r) begin
                        exp_o = 4'b0010; exp_cr = 0;
                        tag = ci ? "R11" : "R7";
                    end else begin
                        exp_cr = ci ? 2 : 1;
                        tag = (a || b) ? "R4" : "R2";
                    end
                end else begin
                    if (r) begin
                        exp_o = 4'b0010; exp_cr = 0;
                        tag = (a || b) ? "R9" : "R7";
                    end else if (a) begin
                        exp_o = 4'b1001; exp_cr = 0;
                        tag = b ? "R9" : "R5";
                    end else if (b) begin
                        exp_o = 4'b0101; exp_cr = 0;
                        tag = "R6";
                    end else begin
                        tag = ci ? "R3" : "R2";
                    end
                end

                do_reset();
                for (int k = 0; k < c; k++) drive(1, 0, 0, 0);
                drive(ci, a, b, r);
                check($sformatf("%s pulse c=%0d in=%b", tag, c, v[3:0]), outs(), exp_o);
                if (exp_o != 4'b0000) begin
                    // R10: hold the same inputs during the pulse cycle
                    drive(ci, a, b, r);
                    check($sformatf("R10 single pulse c=%0d in=%b", c, v[3:0]), outs(), 0);
                end
                probe(cr);
                check($sformatf("%s credit c=%0d in=%b", tag, c, v[3:0]), cr, exp_cr);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule